// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Line Controller

This block watches a set of external pins and turns selected signal transitions into interrupt requests. Each interrupt line has a small multiplexer. The multiplexer chooses which input port feeds the line, always taking the pin whose index matches the line number. The chosen pin goes through a two-stage synchronizer and then an edge detector. Each line can be set to react to rising transitions, falling transitions, both, or neither. A detected transition sets a sticky pending flag. The flag stays set until software clears it by writing a 1 to its bit.

The pending flags are gated by per-line mask bits and then merged onto three shared request outputs. The first output serves lines 0 and 1, the second serves lines 2 and 3, and the third serves all remaining lines from 4 upward. A simple register port sets the selectors, the edge enables and the mask. The same port reads back the pending flags and clears them.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, every selector points at port 0, and all three request outputs are low.
- R2: Line i follows pin i of the port named by its 2-bit selector, which sits at bits [2i+1:2i] of the selector register. Pin i of any other port has no effect on line i.
- R3: When the rising enable of a line is set, a low-to-high transition of its source sets its pending bit.
- R4: When the falling enable of a line is set, a high-to-low transition of its source sets its pending bit.
- R5: When both enables are set, either transition sets the pending bit. When neither is set, no transition sets it.
- R6: A pending bit becomes visible after the third rising clock edge that follows the pin change, and not after the second.
- R7: A pending bit stays set after its source returns to its earlier level, until software clears it.
- R8: Writing 1 to a bit of the pending register clears that bit. Writing 0 leaves the bit unchanged.
- R9: If a qualifying edge on a line is detected in the same cycle as a clear of that line, the pending bit stays set.
- R10: A pending bit is captured whether or not the line's mask bit is set. A request output is raised only for lines whose mask bit is 1.
- R11: irq[0] is the OR of (pending AND mask) over lines 0-1, irq[1] is the same over lines 2-3, and irq[2] is the same over lines 4 and up.
- R12: Register map (bit i = line i): address 0 holds the rising enables, 1 the falling enables, 2 the mask, 3 the pending flags (write-one-to-clear), and 4 the selectors. The configuration registers read back what was written. Writing to address 3 changes no configuration register, and unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_pins | input | NUM_PORTS*NUM_LINES | External pins; pin i of port p is bit p*NUM_LINES+i |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| irq | output | 3 | Shared interrupt request outputs, one per line group |

## Verification
A detected edge and a software clear of the same pending bit can land in the same cycle. The bench sets a line's pending bit with one transition. It then moves the pin again so that the second edge leaves the synchronizer exactly when the write-one-to-clear strobe is on the bus, and it expects the bit to survive. A control case issues the same clear with no edge in flight and expects the bit to drop. The sweep over every line and every port also confirms that the clear and the capture paths leave the neighbouring lines untouched.

// File: rtl/edge_irq_pkg.sv
`timescale 1ns/1ps
package edge_irq_pkg;

  localparam int RA_RISE = 0;
  localparam int RA_FALL = 1;
  localparam int RA_MASK = 2;
  localparam int RA_PEND = 3;
  localparam int RA_SEL  = 4;

  localparam int NUM_GROUPS = 3;

  // Shared request index for a line: 0-1 -> 0, 2-3 -> 1, rest -> 2
  function automatic logic [1:0] line_group(input int unsigned idx);
    if (idx < 2) return 2'd0;
    else if (idx < 4) return 2'd1;
    else return 2'd2;
  endfunction

  // Qualified edge from current and previous synchronized samples
  function automatic logic edge_qualify(input logic cur, input logic prev,
                                        input logic rise_en, input logic fall_en);
    return (rise_en & cur & ~prev) | (fall_en & ~cur & prev);
  endfunction

  // Next pending state: clear first, then a fresh edge wins
  function automatic logic pend_next(input logic cur, input logic clr, input logic hit);
    return (cur & ~clr) | hit;
  endfunction

endpackage

// File: rtl/eirq_line_front.sv
`timescale 1ns/1ps
module eirq_line_front #(
  parameter int NUM_PORTS = 4,
  parameter int SEL_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] src_pins,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 rise_en,
  input  logic                 fall_en,
  output logic                 edge_hit
);
  import edge_irq_pkg::*;

  localparam int SYNC_STAGES = 2;

  logic                 picked;
  logic [SYNC_STAGES:0] shift_q;

  assign picked = src_pins[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[SYNC_STAGES-1:0], picked};
  end

  assign edge_hit = edge_qualify(shift_q[SYNC_STAGES-1], shift_q[SYNC_STAGES],
                                 rise_en, fall_en);
endmodule

// File: rtl/eirq_pend_bank.sv
`timescale 1ns/1ps
module eirq_pend_bank #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] edge_vec,
  input  logic [NUM_LINES-1:0] clr_vec,
  output logic [NUM_LINES-1:0] pend_q
);
  import edge_irq_pkg::*;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_next(pend_q[i], clr_vec[i], edge_vec[i]);
    end
  end
endmodule

// File: rtl/eirq_req_merge.sv
`timescale 1ns/1ps
module eirq_req_merge #(
  parameter int NUM_LINES = 16
) (
  input  logic [NUM_LINES-1:0] pend,
  input  logic [NUM_LINES-1:0] mask,
  output logic [2:0]           irq
);
  import edge_irq_pkg::*;

  always_comb begin
    irq = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      irq[line_group(i)] = irq[line_group(i)] | (pend[i] & mask[i]);
    end
  end
endmodule

// File: rtl/edge_irq_ctrl.sv
`timescale 1ns/1ps
module edge_irq_ctrl #(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
  input  logic                           reg_wr,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [DATA_W-1:0]              reg_wdata,
  output logic [DATA_W-1:0]              reg_rdata,
  output logic [2:0]                     irq
);
  import edge_irq_pkg::*;

  localparam int SEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int SELV_W  = NUM_LINES * SEL_W;

  logic [NUM_LINES-1:0] rise_q, fall_q, mask_q;
  logic [SELV_W-1:0]    sel_q;
  logic [NUM_LINES-1:0] edge_vec, clr_vec, pend_q;

  logic wr_rise, wr_fall, wr_mask, wr_sel, wr_pend;
  assign wr_rise = reg_wr && (reg_addr == ADDR_W'(RA_RISE));
  assign wr_fall = reg_wr && (reg_addr == ADDR_W'(RA_FALL));
  assign wr_mask = reg_wr && (reg_addr == ADDR_W'(RA_MASK));
  assign wr_pend = reg_wr && (reg_addr == ADDR_W'(RA_PEND));
  assign wr_sel  = reg_wr && (reg_addr == ADDR_W'(RA_SEL));

  assign clr_vec = wr_pend ? reg_wdata[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      mask_q <= '0;
      sel_q  <= '0;
    end else begin
      if (wr_rise) rise_q <= reg_wdata[NUM_LINES-1:0];
      if (wr_fall) fall_q <= reg_wdata[NUM_LINES-1:0];
      if (wr_mask) mask_q <= reg_wdata[NUM_LINES-1:0];
      if (wr_sel)  sel_q  <= reg_wdata[SELV_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [NUM_PORTS-1:0] col;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign col[p] = port_pins[p*NUM_LINES + i];
    end
    eirq_line_front #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) front_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_pins (col),
      .sel      (sel_q[i*SEL_W +: SEL_W]),
      .rise_en  (rise_q[i]),
      .fall_en  (fall_q[i]),
      .edge_hit (edge_vec[i])
    );
  end

  eirq_pend_bank #(.NUM_LINES(NUM_LINES)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_vec (edge_vec),
    .clr_vec  (clr_vec),
    .pend_q   (pend_q)
  );

  eirq_req_merge #(.NUM_LINES(NUM_LINES)) merge_i (
    .pend (pend_q),
    .mask (mask_q),
    .irq  (irq)
  );

  always_comb begin
    case (reg_addr)
      ADDR_W'(RA_RISE): reg_rdata = DATA_W'(rise_q);
      ADDR_W'(RA_FALL): reg_rdata = DATA_W'(fall_q);
      ADDR_W'(RA_MASK): reg_rdata = DATA_W'(mask_q);
      ADDR_W'(RA_PEND): reg_rdata = DATA_W'(pend_q);
      ADDR_W'(RA_SEL):  reg_rdata = DATA_W'(sel_q);
      default:          reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/eirq_checker.sv
`timescale 1ns/1ps
module eirq_checker #(
  parameter int NUM_LINES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_LINES-1:0] edge_vec,
  input logic [NUM_LINES-1:0] clr_vec,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [2:0]           irq
);
  // R7: a pending bit only drops after a clear for it
  a_r7_sticky_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend_q & $past(pend_q) & ~$past(clr_vec)) == '0));

  // R9: an edge meeting a clear leaves the bit set
  a_r9_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_vec & clr_vec) != '0) |=> ((pend_q & $past(edge_vec)) == $past(edge_vec)));

  // R3: a pending bit only rises where an edge was detected
  a_r3_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(edge_vec)) == '0));

  // R10: with nothing pending and unmasked, no request
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & mask_q) == '0) |-> (irq == 3'b000));

  // R11: an unmasked pending line always shows on some request
  a_r11_request_seen: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & mask_q) != '0) |-> (irq != 3'b000));
endmodule

bind edge_irq_ctrl eirq_checker #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .pend_q   (pend_q),
  .edge_vec (edge_vec),
  .clr_vec  (clr_vec),
  .mask_q   (mask_q),
  .irq      (irq)
);

// File: tb/edge_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module edge_irq_ctrl_tb_top;
  localparam int NL = 16;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP*NL-1:0] port_pins = '0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [2:0]    irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .port_pins(port_pins), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [2:0] grp_bit(input int l);
    if (l <= 1) return 3'b001;
    if (l <= 3) return 3'b010;
    return 3'b100;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 3'(a);
    #1;
    d = reg_rdata;
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_pin(input int p, input int l, input logic v);
    @(negedge clk);
    port_pins[p*NL + l] = v;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);

    // R1 reset state, R12 unused addresses
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk("R1", v, 32'h0);
    end
    chk("R1 irq", {29'h0, irq}, 32'h0);

    // R12 readback and isolation from pending writes
    wr(0, 32'h0000_A5C3); wr(1, 32'h0000_3C5A); wr(2, 32'h0000_F00F); wr(4, 32'hDEAD_BEEF);
    wr(3, 32'hFFFF_FFFF);
    rd(0, v); chk("R12 rise", v, 32'h0000_A5C3);
    rd(1, v); chk("R12 fall", v, 32'h0000_3C5A);
    rd(2, v); chk("R12 mask", v, 32'h0000_F00F);
    rd(4, v); chk("R12 sel",  v, 32'hDEAD_BEEF);
    rd(3, v); chk("R12 pend", v, 32'h0);
    wr(0, 0); wr(1, 0); wr(2, 0); wr(4, 0);

    // Sweep all lines and ports: R2, R3, R6, R7, R8, R11
    for (int l = 0; l < NL; l++) begin
      for (int p = 0; p < NP; p++) begin
        wr(4, 32'(p) << (2*l));
        wr(0, 32'(1) << l);
        wr(2, 32'(1) << l);
        for (int q = 0; q < NP; q++) begin
          if (q != p) begin
            set_pin(q, l, 1'b1);
            set_pin(q, l, 1'b0);
          end
        end
        cycles(4);
        rd(3, v); chk("R2 other port ignored", v, 32'h0);
        set_pin(p, l, 1'b1);
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(3, v); chk("R6 not after two edges", v, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(3, v); chk("R3/R6 rise captured", v, 32'(1) << l);
        chk("R11 group", {29'h0, irq}, {29'h0, grp_bit(l)});
        set_pin(p, l, 1'b0);
        cycles(4);
        rd(3, v); chk("R7 sticky", v, 32'(1) << l);
        wr(3, 32'(1) << l);
        rd(3, v); chk("R8 cleared", v, 32'h0);
        chk("R8 irq low", {29'h0, irq}, 32'h0);
      end
    end
    wr(4, 0); wr(0, 0); wr(2, 0);

    // R4 falling only on line 5 (port 0)
    wr(1, 32'h20);
    set_pin(0, 5, 1'b1); cycles(4);
    rd(3, v); chk("R4 rise ignored", v, 32'h0);
    set_pin(0, 5, 1'b0); cycles(4);
    rd(3, v); chk("R4 fall captured", v, 32'h20);
    wr(3, 32'h20);

    // R5 both edges, then neither
    wr(0, 32'h20);
    set_pin(0, 5, 1'b1); cycles(4);
    rd(3, v); chk("R5 both rise", v, 32'h20);
    wr(3, 32'h20);
    set_pin(0, 5, 1'b0); cycles(4);
    rd(3, v); chk("R5 both fall", v, 32'h20);
    wr(3, 32'h20);
    wr(0, 0); wr(1, 0);
    set_pin(0, 5, 1'b1); cycles(4); set_pin(0, 5, 1'b0); cycles(4);
    rd(3, v); chk("R5 none", v, 32'h0);

    // R10 mask: capture without request, then request when unmasked
    wr(0, 32'h0100);
    set_pin(0, 8, 1'b1); cycles(4);
    rd(3, v); chk("R10 captured masked", v, 32'h0100);
    chk("R10 no request", {29'h0, irq}, 32'h0);
    wr(2, 32'h0100);
    chk("R10 request after unmask", {29'h0, irq}, 32'h4);
    // R8 writing zero keeps bit
    wr(3, 32'hFFFF_FEFF);
    rd(3, v); chk("R8 write zero keeps", v, 32'h0100);
    wr(3, 32'h0100); wr(2, 0); wr(0, 0);
    set_pin(0, 8, 1'b0); cycles(4);

    // R9 collision: line 2, both edges enabled
    wr(0, 32'h4); wr(1, 32'h4);
    set_pin(0, 2, 1'b1); cycles(4);
    rd(3, v); chk("R9 preset", v, 32'h4);
    set_pin(0, 2, 1'b0);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(3); reg_wdata = 32'h4;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(3, v); chk("R9 edge wins over clear", v, 32'h4);
    wr(3, 32'h4);
    rd(3, v); chk("R9 control clear", v, 32'h0);
    wr(0, 0); wr(1, 0);

    // R11 multiple groups
    wr(0, 32'h0009); wr(2, 32'h0009);
    set_pin(0, 0, 1'b1); set_pin(0, 3, 1'b1); cycles(4);
    chk("R11 two groups", {29'h0, irq}, 32'h3);
    wr(3, 32'h1);
    chk("R11 one group left", {29'h0, irq}, 32'h2);
    wr(3, 32'h8);
    chk("R11 none left", {29'h0, irq}, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule